// File: doc/BRIEF.md
# Hardware Sprite Channel

This block is one hardware sprite channel for a raster display pipeline. A bus master programs it through four write-only 16-bit registers on a plain address, data and strobe bus: a position word, a control word and two image planes. The start and stop coordinates are 9 bits wide, and each is split across the position and control words.

A comparator watches the incoming horizontal beam count and vertical line count. The sprite must be armed, the beam must sit on the programmed start column, and the line must lie inside the programmed vertical window. When all three hold, the comparator copies both image planes into two 16-bit shift lanes. Each lane then gives up one bit per clock, most significant bit first, and together they form a 2-bit pixel code. Writing image plane A arms the channel. Writing the control word disarms it. While the channel stays armed, the same image is drawn again on every line of the window.

The decoded vertical start, vertical stop and attach flag are driven out for neighbouring logic. Each clock edge is one pixel.

Top module: `spr_chan`

## Requirements
- R1: Writes take effect on the clock edge at which wr_en_i is high. Address 0 selects the position word: data bits 15:8 become vertical start bits 7:0 (seen on vstart_o) and data bits 7:0 become horizontal start bits 8:1.
- R2: Address 1 selects the control word. Data bits 15:8 become vertical stop bits 7:0, bit 7 becomes attach_o, bit 2 becomes vertical start bit 8, bit 1 becomes vertical stop bit 8, and bit 0 becomes horizontal start bit 0. Data bits 6:3 are ignored.
- R3: After reset, all registers and shift lanes are zero, the channel is disarmed, and pix_o is 00.
- R4: A write to address 1 disarms the channel from the next cycle on. A disarmed channel never loads its lanes.
- R5: A write to address 2 (plane A) arms the channel. A write to address 3 (plane B) stores plane B and leaves the armed state unchanged.
- R6: A match loads the lanes at the clock edge where the channel is armed and hpos_i equals the horizontal start. It uses the register contents from before any write in that same cycle. Right after that edge pix_o = {B[15], A[15]}. After each further edge the next lower bit appears, so pixel k shows {B[15-k], A[15-k]}.
- R7: Once 16 pixels have been shown, pix_o is 00 (transparent) until the next match.
- R8: A match requires vstart <= vpos_i < vstop. A stop value at or below the start value gives no visible line.
- R9: The channel stays armed after a match, so every line of the window shows the same image again.
- R10: A match while a previous shift is still in progress reloads both lanes at once, and the new image restarts from its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 position, 1 control, 2 plane A, 3 plane B |
| wr_data_i | input | 16 | Write data |
| hpos_i | input | 9 | Horizontal beam count |
| vpos_i | input | 9 | Vertical line count |
| pix_o | output | 2 | Pixel code {plane B bit, plane A bit}; 00 is transparent |
| vstart_o | output | 9 | Decoded vertical start line |
| vstop_o | output | 9 | Decoded vertical stop line |
| attach_o | output | 1 | Attach control flag |

## Verification
The assertions check on every cycle that a control write disarms the channel, that a plane A write arms it, and that a plane B write or an idle cycle leaves the armed state alone. They also check that no load happens while the channel is disarmed or the window is empty, and that the output is transparent once 16 pixels have passed since the last load. Other behaviours can only be shown by the bench scenarios. These are the split bit layout of the coordinates, the most-significant-bit-first order of the pixel stream, the exact boundaries of the vertical window, repetition on successive lines, and the restart when a match comes in the middle of a shift. The bench also runs a random mix of register writes and beam sweeps against its own cycle model.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned COORD_W = 9;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned PLANES  = 2;
  localparam int unsigned HALF_W  = DATA_W / 2;

  // control word bit positions
  localparam int unsigned CTL_ATT = 7;
  localparam int unsigned CTL_VS8 = 2;
  localparam int unsigned CTL_VE8 = 1;
  localparam int unsigned CTL_HS0 = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_POS  = 2'd0,
    REG_CTL  = 2'd1,
    REG_IMGA = 2'd2,
    REG_IMGB = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [COORD_W-1:0] vstart;
    logic [COORD_W-1:0] vstop;
    logic [COORD_W-1:0] hstart;
    logic               attach;
  } spr_geom_t;
endpackage

// File: rtl/spr_regs.sv
module spr_regs
  import spr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output spr_geom_t         geom_o,
  output logic [DATA_W-1:0] img_a_o,
  output logic [DATA_W-1:0] img_b_o,
  output logic              armed_o
);
  spr_geom_t         geom_q;
  logic [DATA_W-1:0] img_a_q, img_b_q;
  logic              armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geom_q  <= '0;
      img_a_q <= '0;
      img_b_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        REG_POS: begin
          geom_q.vstart[HALF_W-1:0]  <= wr_data_i[DATA_W-1:HALF_W];
          geom_q.hstart[COORD_W-1:1] <= wr_data_i[HALF_W-1:0];
        end
        REG_CTL: begin
          geom_q.vstop[HALF_W-1:0]    <= wr_data_i[DATA_W-1:HALF_W];
          geom_q.attach               <= wr_data_i[CTL_ATT];
          geom_q.vstart[COORD_W-1]    <= wr_data_i[CTL_VS8];
          geom_q.vstop[COORD_W-1]     <= wr_data_i[CTL_VE8];
          geom_q.hstart[0]            <= wr_data_i[CTL_HS0];
          armed_q                     <= 1'b0;
        end
        REG_IMGA: begin
          img_a_q <= wr_data_i;
          armed_q <= 1'b1;
        end
        REG_IMGB: img_b_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign geom_o  = geom_q;
  assign img_a_o = img_a_q;
  assign img_b_o = img_b_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/spr_cmp.sv
module spr_cmp
  import spr_pkg::*;
(
  input  logic               armed_i,
  input  logic [COORD_W-1:0] hpos_i,
  input  logic [COORD_W-1:0] vpos_i,
  input  logic [COORD_W-1:0] hstart_i,
  input  logic [COORD_W-1:0] vstart_i,
  input  logic [COORD_W-1:0] vstop_i,
  output logic               load_o
);
  logic h_hit, v_in;

  always_comb begin
    h_hit  = (hpos_i == hstart_i);
    v_in   = (vpos_i >= vstart_i) && (vpos_i < vstop_i);
    load_o = armed_i && h_hit && v_in;
  end
endmodule

// File: rtl/spr_lane.sv
module spr_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= din_i;
    else             sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/spr_chan.sv
module spr_chan
  import spr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [COORD_W-1:0] hpos_i,
  input  logic [COORD_W-1:0] vpos_i,
  output logic [PLANES-1:0]  pix_o,
  output logic [COORD_W-1:0] vstart_o,
  output logic [COORD_W-1:0] vstop_o,
  output logic               attach_o
);
  spr_geom_t                      geom_w;
  logic [PLANES-1:0][DATA_W-1:0]  img_w;
  logic [PLANES-1:0]              msb_w;
  logic                           armed_w;
  logic                           load_w;

  spr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .geom_o    (geom_w),
    .img_a_o   (img_w[0]),
    .img_b_o   (img_w[1]),
    .armed_o   (armed_w)
  );

  spr_cmp u_cmp (
    .armed_i  (armed_w),
    .hpos_i   (hpos_i),
    .vpos_i   (vpos_i),
    .hstart_i (geom_w.hstart),
    .vstart_i (geom_w.vstart),
    .vstop_i  (geom_w.vstop),
    .load_o   (load_w)
  );

  // plane 0 is image A (pixel bit 0), plane 1 is image B (pixel bit 1)
  for (genvar g = 0; g < PLANES; g++) begin : g_lane
    spr_lane #(.W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_w),
      .din_i  (img_w[g]),
      .msb_o  (msb_w[g])
    );
  end

  assign pix_o    = msb_w;
  assign vstart_o = geom_w.vstart;
  assign vstop_o  = geom_w.vstop;
  assign attach_o = geom_w.attach;
endmodule

// File: rtl/spr_chan_chk.sv
module spr_chan_chk
  import spr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [COORD_W-1:0] vstart_i,
  input logic [COORD_W-1:0] vstop_i,
  input logic [PLANES-1:0]  pix_i,
  input logic               armed_i,
  input logic               load_i
);
  localparam logic [4:0] TAIL = 5'(DATA_W);

  logic [4:0] since_load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_load_q <= TAIL;
    else if (load_i)             since_load_q <= '0;
    else if (since_load_q != TAIL) since_load_q <= since_load_q + 5'd1;
  end

  a_r4_ctl_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_CTL) |=> !armed_i);

  a_r4_no_load_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !load_i);

  a_r5_imga_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_IMGA) |=> armed_i);

  a_r5_imgb_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_IMGB) |=> $stable(armed_i));

  a_r9_armed_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(armed_i));

  a_r8_empty_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstop_i <= vstart_i) |-> !load_i);

  a_r7_transparent_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_load_q == TAIL) |-> (pix_i == '0));
endmodule

bind spr_chan spr_chan_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .vstart_i  (vstart_o),
  .vstop_i   (vstop_o),
  .pix_i     (pix_o),
  .armed_i   (armed_w),
  .load_i    (load_w)
);

// File: tb/spr_chan_tb_top.sv
module spr_chan_tb_top;
  import spr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [8:0]  hpos = '0;
  logic [8:0]  vpos = '0;
  logic [1:0]  pix;
  logic [8:0]  vstart, vstop;
  logic        attach;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  // model state, built from the requirements
  logic [8:0]  m_hstart = '0, m_vstart = '0, m_vstop = '0;
  logic        m_attach = 1'b0, m_armed = 1'b0;
  logic [15:0] m_a = '0, m_b = '0, m_sa = '0, m_sb = '0;

  always #2 clk = ~clk;

  spr_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hpos_i(hpos), .vpos_i(vpos), .pix_o(pix),
    .vstart_o(vstart), .vstop_o(vstop), .attach_o(attach)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pix(input logic [15:0] a, input logic [15:0] b, input int k);
    if (k > 15) return 2'b00;
    return {b[15-k], a[15-k]};
  endfunction

  task automatic model_edge(input logic we, input logic [1:0] a, input logic [15:0] d,
                            input logic [8:0] h, input logic [8:0] v);
    logic hit;
    hit = m_armed && (h == m_hstart) && (v >= m_vstart) && (v < m_vstop);
    if (hit) begin m_sa = m_a; m_sb = m_b; end
    else begin m_sa = m_sa << 1; m_sb = m_sb << 1; end
    if (we) begin
      case (a)
        2'd0: begin m_vstart[7:0] = d[15:8]; m_hstart[8:1] = d[7:0]; end
        2'd1: begin
          m_vstop[7:0] = d[15:8]; m_attach = d[7]; m_vstart[8] = d[2];
          m_vstop[8] = d[1]; m_hstart[0] = d[0]; m_armed = 1'b0;
        end
        2'd2: begin m_a = d; m_armed = 1'b1; end
        default: m_b = d;
      endcase
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                      input logic [8:0] h, input logic [8:0] v);
    wr_en = we; wr_addr = a; wr_data = d; hpos = h; vpos = v;
    @(posedge clk);
    model_edge(we, a, d, h, v);
    @(negedge clk);
    chk("R6 model pix", 32'(pix), 32'({m_sb[15], m_sa[15]}));
    chk("R1 model vstart", 32'(vstart), 32'(m_vstart));
    chk("R2 model vstop", 32'(vstop), 32'(m_vstop));
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, a, d, 9'd0, 9'd0);
  endtask

  task automatic line_expect(input logic [8:0] v, input logic [8:0] hs, input logic [15:0] a,
                             input logic [15:0] b, input logic vis, input string tag);
    step(1'b0, 2'd0, 16'h0, hs - 9'd1, v);
    for (int k = 0; k < 19; k++) begin
      step(1'b0, 2'd0, 16'h0, hs + 9'(k), v);
      chk(tag, 32'(pix), vis ? 32'(exp_pix(a, b, k)) : 32'h0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0, 9'd0, 9'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] h, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R3 reset pix", 32'(pix), 32'h0);
    chk("R3 reset vstart", 32'(vstart), 32'h0);
    chk("R3 reset vstop", 32'(vstop), 32'h0);
    chk("R3 reset attach", 32'(attach), 32'h0);
    rst_n = 1'b1;
    idle(2);
    chk("R3 idle pix", 32'(pix), 32'h0);

    // field layout
    wr(REG_POS, 16'h1220);
    chk("R1 vstart low", 32'(vstart), 32'h012);
    wr(REG_CTL, 16'h56FD);
    chk("R2 vstart hi bit", 32'(vstart), 32'h112);
    chk("R2 vstop", 32'(vstop), 32'h056);
    chk("R2 attach", 32'(attach), 32'h1);
    wr(REG_CTL, 16'h5685);
    chk("R2 bits 6:3 ignored vstop", 32'(vstop), 32'h056);
    chk("R2 bits 6:3 ignored vstart", 32'(vstart), 32'h112);
    chk("R2 bits 6:3 ignored attach", 32'(attach), 32'h1);

    // window 10..19, hstart 65
    wr(REG_POS, 16'h0A20);
    wr(REG_CTL, 16'h1401);
    chk("R1 vstart", 32'(vstart), 32'd10);
    chk("R2 attach clear", 32'(attach), 32'h0);
    wr(REG_IMGB, 16'h0FF0);
    wr(REG_IMGA, 16'hC3A5);
    line_expect(9'd12, 9'd65, 16'hC3A5, 16'h0FF0, 1'b1, "R6/R7 line 12");
    line_expect(9'd13, 9'd65, 16'hC3A5, 16'h0FF0, 1'b1, "R9 repeat line 13");
    line_expect(9'd20, 9'd65, 16'hC3A5, 16'h0FF0, 1'b0, "R8 stop line hidden");
    line_expect(9'd9,  9'd65, 16'hC3A5, 16'h0FF0, 1'b0, "R8 before start hidden");
    line_expect(9'd10, 9'd65, 16'hC3A5, 16'h0FF0, 1'b1, "R8 start line shown");
    line_expect(9'd19, 9'd65, 16'hC3A5, 16'h0FF0, 1'b1, "R8 last line shown");

    // retrigger mid-shift
    for (int k = 0; k < 5; k++) step(1'b0, 2'd0, 16'h0, 9'd65 + 9'(k), 9'd15);
    chk("R10 pre-retrigger pixel 4", 32'(pix), 32'(exp_pix(16'hC3A5, 16'h0FF0, 4)));
    step(1'b0, 2'd0, 16'h0, 9'd65, 9'd15);
    chk("R10 reload pixel 0", 32'(pix), 32'(exp_pix(16'hC3A5, 16'h0FF0, 0)));
    step(1'b0, 2'd0, 16'h0, 9'd66, 9'd15);
    chk("R10 reload pixel 1", 32'(pix), 32'(exp_pix(16'hC3A5, 16'h0FF0, 1)));
    idle(20);

    // disarm / arm
    wr(REG_CTL, 16'h1401);
    line_expect(9'd12, 9'd65, 16'h0, 16'h0, 1'b0, "R4 disarmed hidden");
    wr(REG_IMGB, 16'hFFFF);
    line_expect(9'd12, 9'd65, 16'h0, 16'h0, 1'b0, "R5 plane B does not arm");
    wr(REG_IMGA, 16'h8001);
    line_expect(9'd12, 9'd65, 16'h8001, 16'hFFFF, 1'b1, "R5 plane A arms");

    // empty window
    wr(REG_CTL, 16'h0A01);
    wr(REG_IMGA, 16'hFFFF);
    line_expect(9'd10, 9'd65, 16'h0, 16'h0, 1'b0, "R8 empty window line 10");
    line_expect(9'd11, 9'd65, 16'h0, 16'h0, 1'b0, "R8 empty window line 11");

    // random mix against the model
    h = '0; v = '0;
    for (int i = 0; i < 6000; i++) begin
      logic        we;
      logic [1:0]  a;
      logic [15:0] d;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom % 4);
      d  = 16'($urandom);
      if (a == 2'd0) d = {8'($urandom % 32), 8'($urandom % 64)};
      if (a == 2'd1) d = {8'($urandom % 32), 8'($urandom) & 8'hFB};
      step(we, a, d, h, v);
      h = (h == 9'd127) ? 9'd0 : h + 9'd1;
      if (h == 9'd0) v = (v == 9'd31) ? 9'd0 : v + 9'd1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule